// File: doc/BRIEF.md
# Serial Audio Port with External Bit Clock

This block is the host side of a two-channel serial audio link in which the converter drives the bit clock and the host drives the word clock. The port oversamples the incoming bit clock in its own system clock domain. It counts bit-clock cycles and generates an active-low frame sync whose period and low width are programmable. It shifts out a left/right pair of 16-bit samples, MSB first, starting one bit clock after each frame-sync active edge. It shifts in the received pair on the opposite bit-clock edge and presents both words sign-extended to 32 bits.

Software starts the port in two steps. First it releases the sample-rate generator and the frame logic. It then waits for the frame-sync event strobe, which marks the first generated pulse, and only after that enables the transmitter and receiver. An enable change takes effect only at a frame-sync active edge. Audio therefore always starts and stops on a whole stereo frame, while the word clock keeps running.

Samples enter through a one-entry holding buffer with a ready level. If a frame starts while the port is transmitting and no sample is waiting, the port sends silence and raises a sticky underrun flag.

Top module: `i2sx_port`

## Requirements
- R1: After reset, `fsync_no` is high and `sd_o` is low. `tx_ready` is high. `tx_underrun`, `fs_evt` and `rx_valid` are low, and `rx_left` and `rx_right` are zero.
- R2: Control register address 0 holds these bits: bit 0 is generator run, bit 1 is frame run, bit 2 is transmit enable and bit 3 is receive enable. While bit 0 and bit 1 are not both set, `fsync_no` stays high and no `fs_evt` is produced.
- R3: Address 1 holds the period field, which resets to 31. The frame-sync period is the field plus 1 bit clocks. `fsync_no` changes only after falling edges of `bclk_i`.
- R4: Address 2 holds the width field, which resets to 15. `fsync_no` stays low for the field plus 1 bit clocks of each period. `fs_evt` is a single-cycle pulse on each high-to-low transition of `fsync_no`.
- R5: Each transmitted frame carries the left word and then the right word, 16 bits each, MSB first, changing after bit-clock falling edges. A receiver that samples on rising edges sees the first bit at the rising edge after the one at which it first sees `fsync_no` low. It sees the 32nd bit at the rising edge where the next frame sync is first seen low.
- R6: Received bits are sampled on rising edges with the same framing as R5. After the 32nd bit, `rx_valid` pulses for one cycle, and `rx_left` and `rx_right` carry the two words sign-extended to 32 bits.
- R7: The transmit and receive enables are taken only at a frame-sync active edge. If they are set mid-frame, the rest of that frame sends zeros and produces no `rx_valid`.
- R8: Clearing the enables lets the frame in progress complete. From the next frame on, no data is sent or received, a waiting sample stays in the buffer, and the frame sync keeps running.
- R9: `sd_o` is low whenever no word is being shifted out.
- R10: `tx_push` loads `tx_left` and `tx_right` only while `tx_ready` is high, and `tx_ready` then drops. A push while `tx_ready` is low is ignored. `tx_ready` returns high when an active frame takes the pair at its first bit.
- R11: If an active transmit frame starts with an empty buffer, it sends zeros and `tx_underrun` is set. The flag stays set until a write to address 0 with bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| tx_left | input | 16 | Left sample to send |
| tx_right | input | 16 | Right sample to send |
| tx_push | input | 1 | Load the sample pair into the holding buffer |
| tx_ready | output | 1 | Holding buffer is empty |
| tx_underrun | output | 1 | Sticky flag: a frame found no sample |
| rx_left | output | 32 | Last received left word, sign-extended |
| rx_right | output | 32 | Last received right word, sign-extended |
| rx_valid | output | 1 | One-cycle strobe: a new received pair is present |
| fs_evt | output | 1 | One-cycle strobe on each frame-sync active edge |
| bclk_i | input | 1 | Bit clock from the converter |
| fsync_no | output | 1 | Generated word clock, active low |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The bench plays the converter: it drives the bit clock and serial input, and it decodes the serial output relative to the frame sync it samples. It enables the port mid-frame and checks that the partial frame stays silent. A design that started at once would emit a shifted, truncated word, and a design with no one-bit delay would move every bit one slot early. Received words with the top bit set check sign extension, which a zero-fill design would miss. A second push while the buffer is full must be lost and followed by a silent underrun frame; a design that overwrote the buffer would send the wrong pair. A disable issued mid-frame must finish that frame, keep the word clock running and leave the next sample waiting. A reprogrammed period and width must show up in the measured frame sync.

// File: rtl/i2sx_pkg.sv
package i2sx_pkg;
  // configuration register addresses
  localparam logic [1:0] REG_CTL = 2'd0;
  localparam logic [1:0] REG_PER = 2'd1;
  localparam logic [1:0] REG_WID = 2'd2;

  // write-one-to-clear position of the underrun flag in REG_CTL
  localparam int unsigned CTL_UND_CLR_BIT = 4;

  // REG_CTL bits 3..0 (gen_run is bit 0)
  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic frm_run;
    logic gen_run;
  } ctl_t;
endpackage

// File: rtl/i2sx_edge_sync.sv
module i2sx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_i,
  input  logic sd_i,
  output logic bit_rise,
  output logic bit_fall,
  output logic sd_s
);
  // bq[STAGES-1:0] synchronizer, bq[STAGES] previous value for edge detect
  logic [STAGES:0]   bq_q, bq_d;
  logic [STAGES-1:0] sq_q, sq_d;

  always_comb begin
    bq_d = {bq_q[STAGES-1:0], bclk_i};
    sq_d = {sq_q[STAGES-2:0], sd_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq_q <= '0;
      sq_q <= '0;
    end else begin
      bq_q <= bq_d;
      sq_q <= sq_d;
    end
  end

  assign bit_rise = en &  bq_q[STAGES-1] & ~bq_q[STAGES];
  assign bit_fall = en & ~bq_q[STAGES-1] &  bq_q[STAGES];
  assign sd_s     = sq_q[STAGES-1];
endmodule

// File: rtl/i2sx_frame_gen.sv
module i2sx_frame_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] wid_i,
  input  logic             bit_fall,
  output logic             fsync_no,
  output logic             frame_edge,
  output logic             slot_first,
  output logic             step,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic             fs_q, fs_d;
  logic             edge_d, first_d, step_d;
  logic             edge_q, first_q, step_q;

  always_comb begin
    cnt_nx  = (cnt_q >= per_i) ? '0 : cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    fs_d    = fs_q;
    step_d  = run & bit_fall;
    edge_d  = step_d & (cnt_nx == '0);
    first_d = step_d & (cnt_nx == CNT_W'(1));
    if (!run) begin
      cnt_d = per_i;            // first counted fall enters slot 0
      fs_d  = 1'b1;
    end else if (bit_fall) begin
      cnt_d = cnt_nx;
      fs_d  = ~(cnt_nx <= wid_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fs_q    <= 1'b1;
      edge_q  <= 1'b0;
      first_q <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fs_q    <= fs_d;
      edge_q  <= edge_d;
      first_q <= first_d;
      step_q  <= step_d;
    end
  end

  assign fsync_no   = fs_q;
  assign frame_edge = edge_q;
  assign slot_first = first_q;
  assign step       = step_q;
  assign cnt_o      = cnt_q;

  assert_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> fsync_no);
  assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_fall) |=> $stable(fsync_no));
  assert_evt_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |-> !fsync_no);
  assert_evt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> !frame_edge);
endmodule

// File: rtl/i2sx_tx.sv
module i2sx_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              frame_edge,
  input  logic              slot_first,
  input  logic              step,
  input  logic              push_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              ready_o,
  output logic              und_o,
  output logic              sd_o
);
  localparam int unsigned FRAME_BITS = 2 * WORD_W;

  logic                  act_q, act_d;
  logic                  pend_q, pend_d;
  logic [WORD_W-1:0]     hl_q, hl_d, hr_q, hr_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  und_q, und_d;
  logic                  load, accept;

  always_comb begin
    load   = slot_first & act_q;
    accept = push_i & ~pend_q;
    act_d  = frame_edge ? tx_en : act_q;
    pend_d = (pend_q & ~load) | accept;
    hl_d   = accept ? left_i  : hl_q;
    hr_d   = accept ? right_i : hr_q;
    und_d  = load & ~pend_q;
    sh_d   = sh_q;
    if (load)
      sh_d = pend_q ? {hl_q, hr_q} : '0;
    else if (step)
      sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};   // zero fill: line idles low
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      hl_q   <= '0;
      hr_q   <= '0;
      sh_q   <= '0;
      und_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      hl_q   <= hl_d;
      hr_q   <= hr_d;
      sh_q   <= sh_d;
      und_q  <= und_d;
    end
  end

  assign ready_o = ~pend_q;
  assign und_o   = und_q;
  assign sd_o    = sh_q[FRAME_BITS-1];

  assert_ignore_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !ready_o) |=> ($stable(hl_q) && $stable(hr_q)));
  assert_underrun_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_first && act_q && ready_o) |=> und_o);
  assert_take_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_first && act_q && !push_i) |=> ready_o);
endmodule

// File: rtl/i2sx_rx.sv
module i2sx_rx #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RX_W   = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             frame_edge,
  input  logic             bit_rise,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sd_i,
  output logic [RX_W-1:0]  left_o,
  output logic [RX_W-1:0]  right_o,
  output logic             valid_o
);
  localparam int unsigned FRAME_BITS = 2 * WORD_W;
  localparam int unsigned NW         = $clog2(FRAME_BITS + 1);

  logic                  act_q, act_d;
  logic                  busy_q, busy_d;
  logic [NW-1:0]         n_q, n_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d, sh_nx;
  logic [RX_W-1:0]       l_q, l_d, r_q, r_d;
  logic                  vld_q, vld_d;
  logic                  start;

  function automatic logic [RX_W-1:0] sext(input logic [WORD_W-1:0] w);
    return {{(RX_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  always_comb begin
    act_d  = frame_edge ? rx_en : act_q;
    start  = bit_rise & act_q & (cnt_i == CNT_W'(1));
    sh_nx  = {sh_q[FRAME_BITS-2:0], sd_i};
    busy_d = busy_q;
    n_d    = n_q;
    sh_d   = sh_q;
    l_d    = l_q;
    r_d    = r_q;
    vld_d  = 1'b0;
    if (start) begin
      sh_d   = {{(FRAME_BITS-1){1'b0}}, sd_i};
      n_d    = NW'(1);
      busy_d = 1'b1;
    end else if (busy_q && bit_rise) begin
      sh_d = sh_nx;
      n_d  = n_q + NW'(1);
      if (n_q == NW'(FRAME_BITS-1)) begin
        busy_d = 1'b0;
        vld_d  = 1'b1;
        l_d    = sext(sh_nx[FRAME_BITS-1:WORD_W]);
        r_d    = sext(sh_nx[WORD_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      busy_q <= 1'b0;
      n_q    <= '0;
      sh_q   <= '0;
      l_q    <= '0;
      r_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      busy_q <= busy_d;
      n_q    <= n_d;
      sh_q   <= sh_d;
      l_q    <= l_d;
      r_q    <= r_d;
      vld_q  <= vld_d;
    end
  end

  assign left_o  = l_q;
  assign right_o = r_q;
  assign valid_o = vld_q;

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  assert_no_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !busy_q) |=> !valid_o);
endmodule

// File: rtl/i2sx_port.sv
module i2sx_port #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned RX_W        = 32,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  input  logic              tx_push,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic [RX_W-1:0]   rx_left,
  output logic [RX_W-1:0]   rx_right,
  output logic              rx_valid,
  output logic              fs_evt,
  input  logic              bclk_i,
  output logic              fsync_no,
  output logic              sd_o,
  input  logic              sd_i
);
  import i2sx_pkg::*;

  localparam int unsigned FRAME_BITS = 2 * WORD_W;
  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] WID_RST = CNT_W'(WORD_W - 1);

  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] per_q, per_d, wid_q, wid_d;
  logic             und_q, und_d, und_clr, und_set;
  logic             run;
  logic             bit_rise, bit_fall, sd_s;
  logic             frame_edge, slot_first, step;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctl_d   = ctl_q;
    per_d   = per_q;
    wid_d   = wid_q;
    und_clr = 1'b0;
    if (cfg_we) begin
      if (cfg_addr == REG_CTL) begin
        ctl_d   = ctl_t'(cfg_wdata[3:0]);
        und_clr = cfg_wdata[CTL_UND_CLR_BIT];
      end else if (cfg_addr == REG_PER) begin
        per_d = cfg_wdata;
      end else if (cfg_addr == REG_WID) begin
        wid_d = cfg_wdata;
      end
    end
    und_d = und_set | (und_q & ~und_clr);
    run   = ctl_q.gen_run & ctl_q.frm_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      per_q <= PER_RST;
      wid_q <= WID_RST;
      und_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      per_q <= per_d;
      wid_q <= wid_d;
      und_q <= und_d;
    end
  end

  i2sx_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_q.gen_run),
    .bclk_i(bclk_i), .sd_i(sd_i),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .sd_s(sd_s)
  );

  i2sx_frame_gen #(.CNT_W(CNT_W)) fgen_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .per_i(per_q), .wid_i(wid_q), .bit_fall(bit_fall),
    .fsync_no(fsync_no), .frame_edge(frame_edge),
    .slot_first(slot_first), .step(step), .cnt_o(cnt)
  );

  i2sx_tx #(.WORD_W(WORD_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .tx_en(ctl_q.tx_en),
    .frame_edge(frame_edge), .slot_first(slot_first), .step(step),
    .push_i(tx_push), .left_i(tx_left), .right_i(tx_right),
    .ready_o(tx_ready), .und_o(und_set), .sd_o(sd_o)
  );

  i2sx_rx #(.WORD_W(WORD_W), .RX_W(RX_W), .CNT_W(CNT_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .rx_en(ctl_q.rx_en),
    .frame_edge(frame_edge), .bit_rise(bit_rise), .cnt_i(cnt),
    .sd_i(sd_s), .left_o(rx_left), .right_o(rx_right), .valid_o(rx_valid)
  );

  assign fs_evt      = frame_edge;
  assign tx_underrun = und_q;

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun && !und_clr) |=> tx_underrun);
  assert_no_evt_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !fs_evt);
endmodule

// File: tb/i2sx_port_tb.sv
module i2sx_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] tx_left = '0, tx_right = '0;
  logic        tx_push = 1'b0;
  logic        tx_ready, tx_underrun, rx_valid, fs_evt, fsync_no, sd_o;
  logic [31:0] rx_left, rx_right;
  logic        bclk = 1'b0;
  logic        sd_in = 1'b0;

  int total = 0, bad = 0;

  // codec model state
  int          j = 99, since_fall = 0, low_run = 0, last_low = 0, last_per = 0;
  logic        prev_fs = 1'b1, seen_fall = 1'b0, fs_low_seen = 1'b0, sd_hi_seen = 1'b0;
  logic [31:0] cur = '0;
  int          frame_idx = 0;
  logic [15:0] cap_l [64];
  logic [15:0] cap_r [64];
  logic [15:0] rx_pat_l = '0, rx_pat_r = '0;

  // strobe monitor state
  int          evt_cnt = 0, evt_long = 0, rx_seen = 0;
  logic        evt_prev = 1'b0;
  logic [31:0] rx_l_last = '0, rx_r_last = '0;

  i2sx_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_left(tx_left), .tx_right(tx_right),
    .tx_push(tx_push), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .fs_evt(fs_evt), .bclk_i(bclk), .fsync_no(fsync_no), .sd_o(sd_o),
    .sd_i(sd_in)
  );

  initial forever #5 clk = ~clk;

  // converter model: bit clock of 16 system clocks
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      bclk = 1'b1;
      begin
        automatic logic fs = fsync_no;
        automatic logic sd = sd_o;
        automatic int   pos = j + 1;
        if (sd) sd_hi_seen = 1'b1;
        if (!fs) fs_low_seen = 1'b1;
        if (pos >= 1 && pos <= 32) cur = {cur[30:0], sd};
        if (pos == 32) begin
          cap_l[frame_idx % 64] = cur[31:16];
          cap_r[frame_idx % 64] = cur[15:0];
          frame_idx++;
        end
        since_fall++;
        if (prev_fs && !fs) begin
          if (seen_fall) last_per = since_fall;
          since_fall = 0;
          seen_fall  = 1'b1;
          j = 0;
        end else begin
          j = (pos > 1000) ? 1000 : pos;
        end
        if (!fs) low_run = prev_fs ? 1 : low_run + 1;
        else if (!prev_fs) last_low = low_run;
        prev_fs = fs;
      end
      repeat (8) @(negedge clk);
      bclk = 1'b0;
      begin
        automatic int p = j + 1;
        if (p >= 1 && p <= 16)       sd_in = rx_pat_l[16-p];
        else if (p >= 17 && p <= 32) sd_in = rx_pat_r[32-p];
        else                         sd_in = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (fs_evt) evt_cnt++;
    if (fs_evt && evt_prev) evt_long++;
    evt_prev = fs_evt;
    if (rx_valid) begin
      rx_seen++;
      rx_l_last = rx_left;
      rx_r_last = rx_right;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    tx_left = l; tx_right = r; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_frame(input int target);
    while (frame_idx < target) @(negedge clk);
  endtask

  task automatic wait_evts(input int n);
    automatic int t = evt_cnt + n;
    while (evt_cnt < t) @(negedge clk);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1", "fsync_no", 32'(fsync_no), 32'd1);
    chk("R1", "sd_o", 32'(sd_o), 32'd0);
    chk("R1", "tx_ready", 32'(tx_ready), 32'd1);
    chk("R1", "tx_underrun", 32'(tx_underrun), 32'd0);
    chk("R1", "fs_evt/rx_valid", 32'({fs_evt, rx_valid}), 32'd0);
    chk("R1", "rx_left", rx_left, 32'd0);
    chk("R1", "rx_right", rx_right, 32'd0);
  endtask

  task automatic test_hold;
    cfg_write(2'd0, 8'h01);       // generator only
    fs_low_seen = 1'b0;
    repeat (40) @(posedge bclk);
    chk("R2", "fsync low seen, generator only", 32'(fs_low_seen), 32'd0);
    cfg_write(2'd0, 8'h02);       // frame logic only
    repeat (40) @(posedge bclk);
    chk("R2", "fsync low seen, frame only", 32'(fs_low_seen), 32'd0);
    chk("R2", "fs_evt count", 32'(evt_cnt), 32'd0);
  endtask

  task automatic test_timing;
    sd_hi_seen = 1'b0;
    cfg_write(2'd0, 8'h03);
    wait_evts(4);
    chk("R3", "period in bit clocks", 32'(last_per), 32'd32);
    chk("R4", "low width in bit clocks", 32'(last_low), 32'd16);
    chk("R4", "fs_evt longer than one cycle", 32'(evt_long), 32'd0);
  endtask

  task automatic test_idle;
    automatic int f0 = frame_idx;
    wait_frame(f0 + 2);
    chk("R9", "sd_o high while idle", 32'(sd_hi_seen), 32'd0);
    chk("R9", "idle frame", {cap_l[f0 % 64], cap_r[f0 % 64]}, 32'd0);
    chk("R7", "rx_valid before enable", 32'(rx_seen), 32'd0);
  endtask

  task automatic test_stream;
    automatic int base, rxs0, rxs1, ev0;
    rx_pat_l = 16'h8001; rx_pat_r = 16'h1234;
    @(posedge fs_evt);
    repeat (5) @(posedge bclk);
    push_pair(16'hA5C3, 16'h3C5A);
    chk("R10", "tx_ready after push", 32'(tx_ready), 32'd0);
    base = frame_idx;
    rxs0 = rx_seen;
    cfg_write(2'd0, 8'h0F);       // mid-frame enable
    wait_frame(base + 1);
    chk("R7", "partial frame after mid enable", {cap_l[base % 64], cap_r[base % 64]}, 32'd0);
    chk("R7", "rx_valid for partial frame", 32'(rx_seen - rxs0), 32'd0);
    while (!tx_ready) @(negedge clk);
    push_pair(16'h0F0F, 16'hF0F1);
    push_pair(16'h1111, 16'h2222);  // ignored, buffer full
    chk("R10", "tx_ready with pair waiting", 32'(tx_ready), 32'd0);
    wait_frame(base + 2);
    chk("R5", "first full frame", {cap_l[(base+1) % 64], cap_r[(base+1) % 64]}, 32'hA5C33C5A);
    repeat (20) @(negedge clk);
    chk("R6", "rx_valid count", 32'(rx_seen - rxs0), 32'd1);
    chk("R6", "rx_left sign-extended", rx_l_last, 32'hFFFF8001);
    chk("R6", "rx_right", rx_r_last, 32'h00001234);
    wait_frame(base + 3);
    chk("R5", "second frame", {cap_l[(base+2) % 64], cap_r[(base+2) % 64]}, 32'h0F0FF0F1);
    chk("R11", "underrun before empty frame", 32'(tx_underrun), 32'd0);
    wait_frame(base + 4);
    rx_pat_l = 16'h7FFF; rx_pat_r = 16'hFFFE;
    push_pair(16'h5A5A, 16'h0001);
    chk("R10", "ignored push not sent", {cap_l[(base+3) % 64], cap_r[(base+3) % 64]}, 32'd0);
    chk("R11", "underrun set", 32'(tx_underrun), 32'd1);
    cfg_write(2'd0, 8'h1F);       // clear underrun, keep running
    repeat (2) @(negedge clk);
    chk("R11", "underrun cleared", 32'(tx_underrun), 32'd0);
    while (!tx_ready) @(negedge clk);
    push_pair(16'hBEEF, 16'hCAFE);
    repeat (6) @(posedge bclk);
    rxs1 = rx_seen;
    ev0  = evt_cnt;
    cfg_write(2'd0, 8'h03);       // mid-frame disable
    wait_frame(base + 5);
    chk("R8", "frame in progress completes", {cap_l[(base+4) % 64], cap_r[(base+4) % 64]}, 32'h5A5A0001);
    wait_frame(base + 6);
    chk("R8", "frame after disable silent", {cap_l[(base+5) % 64], cap_r[(base+5) % 64]}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R8", "rx_valid after disable", 32'(rx_seen - rxs1), 32'd1);
    chk("R6", "rx_left positive", rx_l_last, 32'h00007FFF);
    chk("R6", "rx_right negative", rx_r_last, 32'hFFFFFFFE);
    chk("R8", "waiting pair kept", 32'(tx_ready), 32'd0);
    chk("R8", "frame sync still running", 32'(evt_cnt - ev0), 32'd2);
    chk("R11", "no underrun while disabled", 32'(tx_underrun), 32'd0);
  endtask

  task automatic test_reprogram;
    cfg_write(2'd1, 8'd47);
    cfg_write(2'd2, 8'd7);
    wait_evts(4);
    chk("R3", "reprogrammed period", 32'(last_per), 32'd48);
    chk("R4", "reprogrammed low width", 32'(last_low), 32'd8);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_hold();
    test_timing();
    test_idle();
    test_stream();
    test_reprogram();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all requirements got=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule